// File: doc/BRIEF.md
# Merging Delay Storage Buffer

This block is a small fully associative store that sits between a request stream and one memory bank. It holds each access that is still owed a response during the delay window. Every slot keeps an address tag, a data word, a "slot in use" flag, a "data has arrived" flag and a reference counter. When a request arrives, the block compares it against every slot in the same cycle. A request whose address is already held joins that slot: its counter goes up and no new bank access is issued. A request for a new address takes the lowest-numbered free slot and raises `req_issue`, which tells the bank to fetch that address.

The bank later writes the fetched word into the slot through the fill port, addressed by slot index. Each response read from a slot returns the stored word and lowers the counter by one. When the counter reaches zero, the slot is released and its flags are cleared, so a stale copy can never be hit. If no slot can take a request, `req_full` tells the requester to stall. This happens when a new address finds every slot busy, or when a held address already has its counter at the maximum.

Top module: `merge_hold_buf`

## Requirements
- R1: After reset every slot is free: with `req_valid` low, `req_hit`, `req_issue` and `req_full` are 0, and the first request to any address misses and is given slot 0.
- R2: A request whose address equals the tag of an in-use slot gives `req_hit`=1 and `req_idx` = that slot in the same cycle, and it does not raise `req_issue`.
- R3: A request that misses while a free slot exists raises `req_issue`, gets `req_idx` = the lowest-numbered free slot, and makes that slot hold the address from the next cycle on.
- R4: A slot's counter rises by one for each accepted request mapped to it and falls by one for each response read from it. The slot stays in use, and keeps hitting, until the number of responses equals the number of accepted requests.
- R5: A response from a slot and an accepted request to the same slot in the same cycle leave its counter unchanged.
- R6: `req_full` is 1, `req_issue` is 0, and nothing changes state when a valid request either misses with every slot in use or hits a slot whose counter is at its maximum (2^CNT_W - 1, which is 15 by default).
- R7: A fill writes `fill_data` into slot `fill_idx` and marks its data as arrived. A response from that slot returns that word on `rsp_data` in the same cycle as `rsp_valid`.
- R8: When a slot's counter returns to zero, its in-use and data-arrived flags are cleared: a later request to the same address misses and allocates again.
- R9: A response is read only from a slot whose data has arrived, and a fill targets only an in-use slot still waiting for data. Breaking either rule is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup/allocate request present |
| req_addr | input | AW | Address of the request |
| req_hit | output | 1 | Request matches an in-use slot |
| req_idx | output | IW | Slot matched or allocated |
| req_issue | output | 1 | New slot allocated; a bank access must be made |
| req_full | output | 1 | Request cannot be taken; requester must stall |
| fill_valid | input | 1 | Bank data returning |
| fill_idx | input | IW | Slot receiving bank data |
| fill_data | input | DW | Data word from the bank |
| rsp_valid | input | 1 | Response being read |
| rsp_idx | input | IW | Slot the response is read from |
| rsp_data | output | DW | Stored word of slot `rsp_idx` |

## Verification
Directed sequences come first. Four distinct addresses sent to three slots separate a correct lowest-free-slot choice from a stall. A repeated address tells merging apart from a second allocation. A response paired with a request on the same slot shows whether the counter is updated correctly when both happen at once. A slot driven to counter saturation and then drained shows that release happens exactly when the response count equals the request count. A random phase follows, drawing from only six addresses so that hits, misses, full stalls, releases and slot reuse are all frequent. A bench-side model of the slots gives the expected hit, index, issue, full and response data for every cycle.

// File: rtl/mhb_pkg.sv
package mhb_pkg;
   // Implementation choice for the free-slot priority search.
   typedef enum logic [0:0] {
      SCAN_LOOP = 1'b0,
      SCAN_MASK = 1'b1
   } scan_e;

   // Index width for n slots (at least one bit).
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mhb_onehot_enc.sv
module mhb_onehot_enc #(
   parameter int unsigned N  = 3,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  oh,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (oh[i]) idx = idx | IW'(i);
      end
   end
endmodule

// File: rtl/mhb_first_free.sv
module mhb_first_free #(
   parameter int unsigned   N    = 3,
   parameter int unsigned   IW   = 2,
   parameter mhb_pkg::scan_e SCAN = mhb_pkg::SCAN_LOOP
) (
   input  logic [N-1:0]  cand,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   generate
      if (SCAN == mhb_pkg::SCAN_LOOP) begin : g_loop
         always_comb begin
            any    = 1'b0;
            idx    = '0;
            onehot = '0;
            for (int i = 0; i < N; i++) begin
               if (cand[i] && !any) begin
                  any       = 1'b1;
                  idx       = IW'(i);
                  onehot[i] = 1'b1;
               end
            end
         end
      end else begin : g_mask
         // lowest set bit isolated by two's complement
         assign onehot = cand & (~cand + N'(1));
         assign any    = |cand;
         mhb_onehot_enc #(.N(N), .IW(IW)) u_enc (
            .oh  (onehot),
            .idx (idx)
         );
      end
   endgenerate
endmodule

// File: rtl/mhb_slot.sv
module mhb_slot #(
   parameter int unsigned AW   = 8,
   parameter int unsigned DW   = 16,
   parameter int unsigned CW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] look_addr,
   input  logic          alloc,
   input  logic          inc,
   input  logic          dec,
   input  logic          fill,
   input  logic [DW-1:0] fill_word,
   output logic          match,
   output logic          in_use,
   output logic          arrived,
   output logic          sat,
   output logic [DW-1:0] word
);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   logic [AW-1:0] tag_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;

   always_comb cnt_nx = cnt_q + CW'(inc) - CW'(dec);

   assign match = in_use && (tag_q == look_addr);
   assign sat   = (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_use  <= 1'b0;
         arrived <= 1'b0;
         cnt_q   <= '0;
         tag_q   <= '0;
         word    <= '0;
      end else begin
         cnt_q <= cnt_nx;
         if (alloc) begin
            in_use  <= 1'b1;
            arrived <= 1'b0;
            tag_q   <= look_addr;
         end
         if (fill) begin
            word    <= fill_word;
            arrived <= 1'b1;
         end
         if (cnt_nx == '0) begin
            in_use  <= 1'b0;
            arrived <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/merge_hold_buf.sv
module merge_hold_buf #(
   parameter int unsigned    K    = 3,
   parameter int unsigned    AW   = 8,
   parameter int unsigned    DW   = 16,
   parameter int unsigned    CW   = 4,
   parameter mhb_pkg::scan_e SCAN = mhb_pkg::SCAN_LOOP,
   localparam int unsigned   IW   = mhb_pkg::idx_w(K)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   output logic          req_hit,
   output logic [IW-1:0] req_idx,
   output logic          req_issue,
   output logic          req_full,
   input  logic          fill_valid,
   input  logic [IW-1:0] fill_idx,
   input  logic [DW-1:0] fill_data,
   input  logic          rsp_valid,
   input  logic [IW-1:0] rsp_idx,
   output logic [DW-1:0] rsp_data
);
   generate
      if (K < 1)  begin : g_bad_k  $error("merge_hold_buf: K must be at least 1"); end
      if (AW < 1) begin : g_bad_aw $error("merge_hold_buf: AW must be at least 1"); end
      if (DW < 1) begin : g_bad_dw $error("merge_hold_buf: DW must be at least 1"); end
      if (CW < 2) begin : g_bad_cw $error("merge_hold_buf: CW must be at least 2"); end
   endgenerate

   logic [K-1:0]  match_vec;
   logic [K-1:0]  valid_vec;
   logic [K-1:0]  ready_vec;
   logic [K-1:0]  sat_vec;
   logic [K-1:0]  alloc_oh;
   logic [DW-1:0] slot_word [K];
   logic [IW-1:0] hit_idx;
   logic [IW-1:0] alloc_idx;
   logic          free_any;
   logic          any_match;
   logic          hit_sat;
   logic          accept;

   mhb_onehot_enc #(.N(K), .IW(IW)) u_hit_enc (
      .oh  (match_vec),
      .idx (hit_idx)
   );

   mhb_first_free #(.N(K), .IW(IW), .SCAN(SCAN)) u_free (
      .cand   (~valid_vec),
      .any    (free_any),
      .idx    (alloc_idx),
      .onehot (alloc_oh)
   );

   assign any_match = |match_vec;
   assign hit_sat   = |(match_vec & sat_vec);
   assign req_hit   = req_valid && any_match;
   assign req_full  = req_valid && (any_match ? hit_sat : !free_any);
   assign accept    = req_valid && !req_full;
   assign req_issue = accept && !any_match;
   assign req_idx   = any_match ? hit_idx : alloc_idx;

   generate
      for (genvar i = 0; i < K; i++) begin : g_slot
         logic s_inc, s_dec, s_fill, s_alloc;
         assign s_alloc = req_issue && alloc_oh[i];
         assign s_inc   = accept && (any_match ? match_vec[i] : alloc_oh[i]);
         assign s_dec   = rsp_valid && (rsp_idx == IW'(i)) && valid_vec[i];
         assign s_fill  = fill_valid && (fill_idx == IW'(i));

         mhb_slot #(.AW(AW), .DW(DW), .CW(CW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .look_addr (req_addr),
            .alloc     (s_alloc),
            .inc       (s_inc),
            .dec       (s_dec),
            .fill      (s_fill),
            .fill_word (fill_data),
            .match     (match_vec[i]),
            .in_use    (valid_vec[i]),
            .arrived   (ready_vec[i]),
            .sat       (sat_vec[i]),
            .word      (slot_word[i])
         );
      end
   endgenerate

   always_comb begin
      rsp_data = '0;
      for (int i = 0; i < K; i++) begin
         if (rsp_idx == IW'(i)) rsp_data = slot_word[i];
      end
   end
endmodule

// File: rtl/mhb_chk.sv
module mhb_chk #(
   parameter int unsigned K  = 3,
   parameter int unsigned IW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_hit,
   input logic          req_issue,
   input logic          req_full,
   input logic [IW-1:0] req_idx,
   input logic          fill_valid,
   input logic [IW-1:0] fill_idx,
   input logic          rsp_valid,
   input logic [IW-1:0] rsp_idx,
   input logic [K-1:0]  valid_vec,
   input logic [K-1:0]  ready_vec,
   input logic [K-1:0]  match_vec
);
   localparam logic [K-1:0] ONE = K'(1);

   p_match_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   p_hit_no_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_hit |-> !req_issue);

   p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_issue |-> !valid_vec[req_idx]);

   p_alloc_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_issue |-> (((~valid_vec) & ((ONE << req_idx) - ONE)) == '0));

   p_alloc_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_issue |=> valid_vec[$past(req_idx)]);

   p_incdec_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && req_hit && !req_full && rsp_idx == req_idx)
      |=> valid_vec[$past(req_idx)]);

   p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_full |-> (req_valid && !req_issue));

   p_fill_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (valid_vec[fill_idx] && !ready_vec[fill_idx]));

   p_rsp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ready_vec[rsp_idx]);

   generate
      for (genvar i = 0; i < K; i++) begin : g_free
         p_free_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(valid_vec[i]) |-> !ready_vec[i]);
      end
   endgenerate
endmodule

bind merge_hold_buf mhb_chk #(.K(K), .IW(IW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_hit    (req_hit),
   .req_issue  (req_issue),
   .req_full   (req_full),
   .req_idx    (req_idx),
   .fill_valid (fill_valid),
   .fill_idx   (fill_idx),
   .rsp_valid  (rsp_valid),
   .rsp_idx    (rsp_idx),
   .valid_vec  (valid_vec),
   .ready_vec  (ready_vec),
   .match_vec  (match_vec)
);

// File: tb/sim_merge_hold_buf.sv
`timescale 1ns/1ps
module sim_merge_hold_buf;
   localparam int K   = 3;
   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int IW  = 2;
   localparam int MAXC = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_hit;
   logic [IW-1:0] req_idx;
   logic          req_issue;
   logic          req_full;
   logic          fill_valid = 1'b0;
   logic [IW-1:0] fill_idx = '0;
   logic [DW-1:0] fill_data = '0;
   logic          rsp_valid = 1'b0;
   logic [IW-1:0] rsp_idx = '0;
   logic [DW-1:0] rsp_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the slots
   bit          m_valid [K];
   bit          m_rdy   [K];
   int          m_cnt   [K];
   logic [AW-1:0] m_tag [K];
   logic [DW-1:0] m_data[K];

   always #2 clk = ~clk;

   merge_hold_buf u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr),
      .req_hit(req_hit), .req_idx(req_idx),
      .req_issue(req_issue), .req_full(req_full),
      .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
      .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data)
   );

   task automatic check(input longint act, input longint exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int find_slot(input logic [AW-1:0] a);
      for (int i = 0; i < K; i++) if (m_valid[i] && m_tag[i] == a) return i;
      return -1;
   endfunction

   function automatic int first_free();
      for (int i = 0; i < K; i++) if (!m_valid[i]) return i;
      return -1;
   endfunction

   task automatic cycle(input bit rv, input logic [AW-1:0] ra,
                        input bit fv, input int fi, input logic [DW-1:0] fd,
                        input bit sv, input int si, input string note);
      int  h;
      int  f;
      bit  e_full;
      bit  e_issue;
      @(negedge clk);
      req_valid  = rv;  req_addr = ra;
      fill_valid = fv;  fill_idx = IW'(fi); fill_data = fd;
      rsp_valid  = sv;  rsp_idx  = IW'(si);
      #1;
      h = find_slot(ra);
      f = first_free();
      e_full  = rv && ((h >= 0) ? (m_cnt[h] == MAXC) : (f < 0));
      e_issue = rv && !e_full && (h < 0);
      check(req_hit,   rv && (h >= 0), {"R2 hit ", note});
      check(req_full,  e_full,        {"R6 full ", note});
      check(req_issue, e_issue,       {"R3 issue ", note});
      if (rv && !e_full) begin
         if (h >= 0) check(req_idx, h, {"R2 index ", note});
         else        check(req_idx, f, {"R3 index ", note});
      end
      if (sv) check(rsp_data, m_data[si], {"R7 data ", note});
      @(posedge clk);
      if (sv) m_cnt[si]--;
      if (rv && !e_full) begin
         if (h >= 0) m_cnt[h]++;
         else begin
            m_valid[f] = 1'b1; m_tag[f] = ra; m_cnt[f] = 1; m_rdy[f] = 1'b0;
         end
      end
      if (fv) begin m_data[fi] = fd; m_rdy[fi] = 1'b1; end
      for (int i = 0; i < K; i++)
         if (m_valid[i] && m_cnt[i] == 0) begin m_valid[i] = 1'b0; m_rdy[i] = 1'b0; end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < K; i++) begin
         m_valid[i] = 0; m_rdy[i] = 0; m_cnt[i] = 0; m_tag[i] = '0; m_data[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: idle outputs after reset, first request goes to slot 0
      #1;
      check(req_hit, 0, "R1 idle hit");
      check(req_full, 0, "R1 idle full");
      check(req_issue, 0, "R1 idle issue");
      cycle(1, 8'd10, 0, 0, '0, 0, 0, "R1 first");
      // merge, then fill the remaining slots, then stall
      cycle(1, 8'd10, 0, 0, '0, 0, 0, "merge");
      cycle(1, 8'd20, 0, 0, '0, 0, 0, "slot1");
      cycle(1, 8'd30, 0, 0, '0, 0, 0, "slot2");
      cycle(1, 8'd40, 0, 0, '0, 0, 0, "R6 all busy");
      cycle(1, 8'd40, 0, 0, '0, 0, 0, "R6 nothing allocated");
      // fills
      cycle(0, 8'd0, 1, 0, 16'hAAAA, 0, 0, "R7 fill0");
      cycle(0, 8'd0, 1, 1, 16'hBBBB, 0, 0, "R7 fill1");
      cycle(0, 8'd0, 1, 2, 16'hCCCC, 0, 0, "R7 fill2");
      // slot 0 holds two references
      cycle(0, 8'd0, 0, 0, '0, 1, 0, "R4 first response");
      cycle(1, 8'd10, 0, 0, '0, 1, 0, "R5 inc and dec");
      cycle(1, 8'd10, 0, 0, '0, 0, 0, "R5 still held");
      cycle(0, 8'd0, 0, 0, '0, 1, 0, "R4 response");
      cycle(0, 8'd0, 0, 0, '0, 1, 0, "R4 last response");
      cycle(1, 8'd10, 0, 0, '0, 0, 0, "R8 no stale hit");
      // saturate slot 0 (addr 10, count 1)
      for (int n = 0; n < MAXC - 1; n++) cycle(1, 8'd10, 0, 0, '0, 0, 0, "R4 count up");
      cycle(1, 8'd10, 0, 0, '0, 0, 0, "R6 saturated");
      cycle(0, 8'd0, 1, 0, 16'h1234, 0, 0, "R7 refill");
      for (int n = 0; n < MAXC - 1; n++) begin
         cycle(0, 8'd0, 0, 0, '0, 1, 0, "R4 drain");
         cycle(1, 8'd10, 0, 0, '0, 0, 0, "R4 held while owed");
         cycle(0, 8'd0, 0, 0, '0, 1, 0, "R4 drain");
      end
      // drain the remaining references of all slots
      for (int i = 0; i < K; i++)
         while (m_valid[i]) cycle(0, 8'd0, 0, 0, '0, 1, i, "R4 drain all");
      cycle(1, 8'd20, 0, 0, '0, 0, 0, "R8 reuse lowest");

      // random phase
      for (int c = 0; c < 4000; c++) begin
         bit rv, fv, sv;
         int fi, si, nf, ns;
         int fl [K];
         int sl [K];
         nf = 0; ns = 0;
         for (int i = 0; i < K; i++) begin
            if (m_valid[i] && !m_rdy[i]) begin fl[nf] = i; nf++; end
            if (m_valid[i] && m_rdy[i])  begin sl[ns] = i; ns++; end
         end
         rv = ($urandom % 3) != 0;
         fv = (nf > 0) && ($urandom % 2);
         sv = (ns > 0) && ($urandom % 2);
         fi = fv ? fl[$urandom % nf] : 0;
         si = sv ? sl[$urandom % ns] : 0;
         cycle(rv, AW'($urandom % 6), fv, fi, DW'($urandom), sv, si, "random");
      end
      finish_run();
   end
endmodule